// File: doc/BRIEF.md
# Interrupt Enable and Vector Unit

This block gathers interrupt requests from six sources (two external pins, three timer flags and a serial flag pair), gates them through an 8-bit enable register and presents the CPU with one request strobe and the 16-bit entry address of the chosen source. Each external pin is active low and can be set to either of two trigger styles. In level style, a request stands while the pin is held low. In falling-edge style, a high-to-low change latches a pending flag that stays set until the CPU takes that vector.

Software programs the unit through a small byte bus. Address 0 holds the enable register and address 1 holds the trigger-style bits. The CPU watches `irq_req`. When it takes the interrupt it pulses `irq_ack` for one cycle, and a latched edge flag behind the presented vector is cleared. Timer and serial flags are levels owned by their peripherals and pass straight through.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, address 0 and address 1 both read 0x00 and `irq_req` is low with `irq_vector` at 0x0000.
- R2: While enable bit 7 (global gate) is 0, `irq_req` stays low whatever the other enable bits and the sources hold.
- R3: While bit 7 is 1, source k (bit k of the enable register: 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2) is requested only if its bit is 1.
- R4: The presented vector for source index k is 0x0003 + 8*k: 0x0003, 0x000B, 0x0013, 0x001B, 0x0023, 0x002B.
- R5: When several enabled sources request together, the lowest index wins (ext0, timer0, ext1, timer1, serial, timer2).
- R6: The serial source is the OR of `ser_rx_flag` and `ser_tx_flag`. The timer2 source is the OR of `tmr2_ovf_flag` and `tmr2_ext_flag`.
- R7: Enable bit 6 always reads 0 and ignores writes. Bits 7:2 of address 1 always read 0.
- R8: With the trigger bit at 0 (address 1 bit 0 for ext0, bit 1 for ext1), the pin requests from the first clock edge that samples it low and stops at the first edge that samples it high.
- R9: With the trigger bit at 1, a pin sampled high and then low on the next edge sets a pending flag one edge later. The flag holds after the pin returns high.
- R10: An `irq_ack` while a latched external source's vector is presented clears that flag. An ack while another vector is presented leaves it set.
- R11: An edge flag latches even while its source is disabled, and it is presented once enabled.
- R12: Writes take effect on the clock edge with `reg_wr` high. `reg_rdata` shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 1 | 0 enable register, 1 trigger-style register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of addressed register |
| ext0_n | input | 1 | External pin 0, active low |
| ext1_n | input | 1 | External pin 1, active low |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| tmr2_ovf_flag | input | 1 | Timer 2 overflow flag |
| tmr2_ext_flag | input | 1 | Timer 2 external flag |
| irq_ack | input | 1 | CPU acknowledge strobe |
| irq_req | output | 1 | Request strobe to CPU |
| irq_vector | output | 16 | Entry address of chosen source |

## Verification
The internal sources are swept over all 64 flag combinations against all 128 settings of the gate and the six source enables, so the effects of gating, priority and flag merging are separated from each other. Every byte value is written to the enable register to expose any leak through the reserved bit. Each external pin is then driven in both trigger styles: a short low pulse separates latching from level following, and acks with the pin's own vector and with a competing vector present show whether the clear is tied to the selected source.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int SRC_N    = 6;
    localparam int EXT_N    = 2;
    localparam int IDX_W    = $clog2(SRC_N);
    localparam int VEC_W    = 16;
    localparam int REG_W    = 8;
    localparam int VEC_BASE = 3;
    localparam int VEC_STEP = 8;

    typedef enum logic [IDX_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5
    } src_e;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_FALL  = 1'b1
    } trig_e;

    typedef struct packed {
        logic             gate;
        logic             rsvd;
        logic [SRC_N-1:0] src_en;
    } enable_reg_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // Entry address of a source index
    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        return VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STEP);
    endfunction

    // Source slot taken by external pin e in the priority list
    function automatic logic [IDX_W-1:0] ext_slot(input int e);
        return (e == 0) ? SRC_EXT0 : SRC_EXT1;
    endfunction
endpackage

// File: rtl/irqv_cfg_regs.sv
module irqv_cfg_regs
    import irqv_pkg::*;
#(
    parameter int NEXT = EXT_N,
    parameter int RW   = REG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_addr,
    input  logic            reg_wr,
    input  logic [RW-1:0]   reg_wdata,
    output logic [RW-1:0]   reg_rdata,
    output enable_reg_t     en_q,
    output logic [NEXT-1:0] trig_q
);
    localparam int PAD_W = RW - NEXT;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            trig_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == 1'b0) begin
                en_q      <= enable_reg_t'(reg_wdata);
                en_q.rsvd <= 1'b0;
            end else begin
                trig_q <= reg_wdata[NEXT-1:0];
            end
        end
    end

    always_comb begin
        if (reg_addr == 1'b0) reg_rdata = RW'(en_q);
        else                  reg_rdata = {{PAD_W{1'b0}}, trig_q};
    end
endmodule

// File: rtl/irqv_pin_cond.sv
module irqv_pin_cond
    import irqv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_n,
    input  trig_e mode,
    input  logic  take,
    output logic  req,
    output logic  fall,
    output logic  pend
);
    logic smp_now, smp_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_now <= 1'b1;
            smp_old <= 1'b1;
        end else begin
            smp_now <= pin_n;
            smp_old <= smp_now;
        end
    end

    assign fall = smp_old & ~smp_now;

    always_ff @(posedge clk) begin
        if (rst)                    pend <= 1'b0;
        else if (mode == TRIG_LEVEL) pend <= 1'b0;
        else if (fall)              pend <= 1'b1;
        else if (take)              pend <= 1'b0;
    end

    assign req = (mode == TRIG_LEVEL) ? ~smp_now : pend;
endmodule

// File: rtl/irqv_prio_pick.sv
module irqv_prio_pick
    import irqv_pkg::*;
#(
    parameter int N  = SRC_N,
    parameter int IW = IDX_W
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irqv_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_addr,
    input  logic          reg_wr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic          ext0_n,
    input  logic          ext1_n,
    input  logic          tmr0_flag,
    input  logic          tmr1_flag,
    input  logic          ser_rx_flag,
    input  logic          ser_tx_flag,
    input  logic          tmr2_ovf_flag,
    input  logic          tmr2_ext_flag,
    input  logic          irq_ack,
    output logic          irq_req,
    output logic [VW-1:0] irq_vector
);
    enable_reg_t      en_q;
    logic [EXT_N-1:0] trig_q;
    logic [EXT_N-1:0] ext_pins, ext_req, ext_fall, ext_pend, ext_take;
    logic [SRC_N-1:0] src_raw, src_gated;
    pick_t            pick;

    irqv_cfg_regs #(.NEXT(EXT_N), .RW(RW)) u_regs (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .en_q(en_q), .trig_q(trig_q)
    );

    assign ext_pins = {ext1_n, ext0_n};

    for (genvar e = 0; e < EXT_N; e++) begin : g_ext
        assign ext_take[e] = irq_ack & pick.valid & (pick.idx == ext_slot(e));
        irqv_pin_cond u_pin (
            .clk(clk), .rst(rst), .pin_n(ext_pins[e]),
            .mode(trig_e'(trig_q[e])), .take(ext_take[e]),
            .req(ext_req[e]), .fall(ext_fall[e]), .pend(ext_pend[e])
        );
    end

    always_comb begin
        src_raw           = '0;
        src_raw[SRC_EXT0] = ext_req[0];
        src_raw[SRC_TMR0] = tmr0_flag;
        src_raw[SRC_EXT1] = ext_req[1];
        src_raw[SRC_TMR1] = tmr1_flag;
        src_raw[SRC_SER]  = ser_rx_flag | ser_tx_flag;
        src_raw[SRC_TMR2] = tmr2_ovf_flag | tmr2_ext_flag;
    end

    assign src_gated = en_q.gate ? (src_raw & en_q.src_en) : '0;

    irqv_prio_pick #(.N(SRC_N), .IW(IDX_W)) u_pick (
        .req(src_gated), .valid(pick.valid), .idx(pick.idx)
    );

    assign irq_req    = pick.valid;
    assign irq_vector = pick.valid ? VW'(vec_of(pick.idx)) : '0;
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk
    import irqv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             irq_req,
    input logic             irq_ack,
    input logic [VEC_W-1:0] irq_vector,
    input logic             reg_addr,
    input logic [REG_W-1:0] reg_rdata,
    input enable_reg_t      en_q,
    input logic [EXT_N-1:0] trig_q,
    input logic [EXT_N-1:0] ext_fall,
    input logic [EXT_N-1:0] ext_pend
);
    logic [VEC_W-1:0] slot;
    assign slot = (irq_vector - VEC_W'(VEC_BASE)) >> 3;

    p_gate_off_r2: assert property (@(posedge clk) disable iff (rst)
        !en_q.gate |-> !irq_req);

    p_vec_map_r4: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vector[2:0] == 3'd3 && irq_vector[VEC_W-1:3] < SRC_N));

    p_own_enable_r3: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> en_q.src_en[slot[IDX_W-1:0]]);

    p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !reg_addr |-> !reg_rdata[6]);

    p_edge_set_r9: assert property (@(posedge clk) disable iff (rst)
        (trig_q[0] && ext_fall[0]) |=> ext_pend[0]);

    p_ack_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack && irq_vector == 16'h0003 && !ext_fall[0] && trig_q[0])
        |=> !ext_pend[0]);
endmodule

bind irq_vector_unit irq_vector_chk u_chk (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_ack(irq_ack),
    .irq_vector(irq_vector), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .en_q(en_q), .trig_q(trig_q), .ext_fall(ext_fall), .ext_pend(ext_pend)
);

// File: tb/tb_irq_vector_unit.sv
module tb_irq_vector_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_addr = 1'b0, reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        ext0_n = 1'b1, ext1_n = 1'b1;
    logic        tmr0_flag = 0, tmr1_flag = 0, ser_rx_flag = 0, ser_tx_flag = 0;
    logic        tmr2_ovf_flag = 0, tmr2_ext_flag = 0, irq_ack = 0;
    logic        irq_req;
    logic [15:0] irq_vector;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irq_vector_unit dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext0_n(ext0_n), .ext1_n(ext1_n), .tmr0_flag(tmr0_flag),
        .tmr1_flag(tmr1_flag), .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
        .tmr2_ovf_flag(tmr2_ovf_flag), .tmr2_ext_flag(tmr2_ext_flag),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_vector(irq_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic r, input logic [15:0] v);
        check(req, {15'd0, irq_req, irq_vector}, {15'd0, r, v});
    endtask

    // drive at negedge, write lands at next posedge, back at negedge
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, {24'd0, reg_rdata}, {24'd0, exp});
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    function automatic logic [16:0] model(input logic [7:0] en, input logic [5:0] flags);
        logic [5:0] p;
        p = 6'(flags[0] ? 1 : 0) << 1;           // timer0 -> slot 1
        p[3] = flags[1];                          // timer1 -> slot 3
        p[4] = flags[2] | flags[3];               // serial rx|tx -> slot 4
        p[5] = flags[4] | flags[5];               // timer2 ovf|ext -> slot 5
        p = en[7] ? (p & en[5:0]) : 6'd0;
        for (int k = 0; k < 6; k++)
            if (p[k]) return {1'b1, 16'(3 + 8 * k)};
        return 17'd0;
    endfunction

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd("R1 enable reg", 1'b0, 8'h00);
        rd("R1 trigger reg", 1'b1, 8'h00);
        check_out("R1 idle outputs", 1'b0, 16'h0000);

        // R7, R12: every byte into the enable register
        for (int v = 0; v < 256; v++) begin
            wr(1'b0, 8'(v));
            rd("R7 R12 enable readback", 1'b0, 8'(v) & 8'hBF);
        end
        wr(1'b1, 8'hFF);
        rd("R7 trigger upper bits", 1'b1, 8'h03);
        wr(1'b1, 8'h00);

        // R2-R6: all 128 gate/enable settings x 64 flag patterns
        for (int e = 0; e < 128; e++) begin
            wr(1'b0, {e[6], 1'b0, e[5:0]});
            for (int f = 0; f < 64; f++) begin
                logic [16:0] m;
                {tmr2_ext_flag, tmr2_ovf_flag, ser_tx_flag, ser_rx_flag, tmr1_flag, tmr0_flag} = 6'(f);
                #5;
                m = model({e[6], 1'b0, e[5:0]}, 6'(f));
                check("R2 R3 R4 R5 R6 sweep", {15'd0, irq_req, irq_vector}, {15'd0, m});
                @(negedge clk);
            end
        end
        {tmr2_ext_flag, tmr2_ovf_flag, ser_tx_flag, ser_rx_flag, tmr1_flag, tmr0_flag} = 6'd0;

        // R8 level style on ext0
        wr(1'b0, 8'h85);
        ext0_n = 1'b0;
        @(negedge clk);
        check_out("R8 ext0 low requests", 1'b1, 16'h0003);
        ack_pulse();
        check_out("R8 level not cleared by ack", 1'b1, 16'h0003);
        ext0_n = 1'b1;
        @(negedge clk);
        check_out("R8 ext0 high drops", 1'b0, 16'h0000);
        ext1_n = 1'b0;
        @(negedge clk);
        check_out("R8 ext1 level", 1'b1, 16'h0013);
        ext1_n = 1'b1;
        @(negedge clk);

        // R9 falling-edge style on ext0
        wr(1'b1, 8'h01);
        ext0_n = 1'b0;
        @(negedge clk);
        check_out("R9 one edge after fall not yet latched", 1'b0, 16'h0000);
        ext0_n = 1'b1;
        @(negedge clk);
        check_out("R9 latched after pulse", 1'b1, 16'h0003);
        repeat (3) @(negedge clk);
        check_out("R9 latch holds", 1'b1, 16'h0003);

        // R10 ack while ext0 presented clears it
        ack_pulse();
        check_out("R10 ack clears ext0", 1'b0, 16'h0000);

        // R10 ack with another vector presented leaves ext1 latched
        wr(1'b1, 8'h02);
        wr(1'b0, 8'h86);
        tmr0_flag = 1'b1;
        ext1_n = 1'b0;
        @(negedge clk);
        ext1_n = 1'b1;
        @(negedge clk);
        check_out("R5 timer0 ahead of ext1", 1'b1, 16'h000B);
        ack_pulse();
        tmr0_flag = 1'b0;
        #1;
        check_out("R10 ext1 kept after foreign ack", 1'b1, 16'h0013);
        @(negedge clk);
        ack_pulse();
        check_out("R10 ext1 cleared by own ack", 1'b0, 16'h0000);

        // R11 latch while disabled
        wr(1'b0, 8'h00);
        ext1_n = 1'b0;
        @(negedge clk);
        ext1_n = 1'b1;
        @(negedge clk);
        check_out("R11 disabled, no request", 1'b0, 16'h0000);
        wr(1'b0, 8'h84);
        check_out("R11 presented once enabled", 1'b1, 16'h0013);
        wr(1'b0, 8'h04);
        check_out("R2 gate off hides latch", 1'b0, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule